// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a group of memory blocks that several cores cache privately. For each block it keeps a directory entry and a data word. The entry holds a sharing state (Uncached, Shared or Exclusive) and a bit vector with one bit per node. When a block is Exclusive, the one set bit in the vector names the owner, and the word held in memory is out of date. Nodes send read-miss, write-miss and write-back requests through a valid/ready request port.

The controller serves one request at a time. It answers on a single valid/ready message port, which carries data replies, invalidates, fetches and fetch-invalidates. An owner that is asked for a block returns the data on a separate valid/ready response port. Every invalidate and fetch that a transaction needs goes out before the requester gets its data reply. Until the transaction ends with that reply, the request port stays closed.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and msg_valid is 0. Every block is Uncached and its memory word is zero. Request kind encodings: 0 = read miss, 1 = write miss, 2 = write-back, 3 = unused. Message kind encodings: 0 = data reply, 1 = invalidate, 2 = fetch, 3 = fetch-invalidate.
- R2: A read miss to an Uncached block produces one data reply to the requester that carries the memory word. The block becomes Shared, with only the requester in its sharer set.
- R3: A read miss to a Shared block produces one data reply that carries the memory word. The requester is added to the sharer set, and no other message is sent.
- R4: A write miss to an Uncached block produces one data reply that carries the memory word. The block becomes Exclusive, owned by the requester.
- R5: A write miss to a Shared block sends one invalidate to each sharer other than the requester, one message each, in ascending node order. The data reply to the requester follows them. The block then becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch to the owner and waits for the response. The returned word is written to memory and forwarded to the requester in the data reply. The block becomes Shared, with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-invalidate to the owner and forwards the returned word to the requester in the data reply. The requester becomes the sole owner, and the block stays Exclusive.
- R8: A write-back from the owner of an Exclusive block writes the request data into memory and makes the block Uncached with no sharers. It sends no message, and req_ready is 1 again on the next cycle.
- R9: A write-back from a node that does not own the block, a write-back to a block that is not Exclusive, and a request of kind 3 all leave the directory and memory unchanged and send no message.
- R10: Once a read or write miss is accepted, req_ready stays 0 until the data reply for that miss has been taken.
- R11: While msg_valid is 1 and msg_ready is 0, msg_valid and every message field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | Request kind (see R1) |
| req_node | input | NID_W | Requesting node |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network accepts the message |
| msg_kind | output | 2 | Message kind (see R1) |
| msg_node | output | NID_W | Destination node |
| msg_blk | output | BLK_W | Block index |
| msg_data | output | DATA_W | Reply data (zero for other kinds) |
| rsp_valid | input | 1 | Owner data returned |
| rsp_ready | output | 1 | Controller waits for owner data |
| rsp_data | input | DATA_W | Owner's copy of the block |

## Verification
Only one pair of functions can fall in the same cycle: the network stalling an outgoing message, and the controller stepping through its queue of pending invalidates. If the controller advanced on a stalled cycle, a sharer would be skipped or the wrong node would be named. The bench forces this case by holding msg_ready low on a fixed pattern of cycles during the multi-sharer write misses. Its scoreboard then requires exactly one invalidate per sharer, in ascending order, followed by the data reply. A separate property requires message fields to hold steady across every stalled cycle.

// File: rtl/dir_pkg.sv
package dir_pkg;

   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dir_state_e;

   typedef enum logic [2:0] {
      F_IDLE  = 3'd0,
      F_INV   = 3'd1,
      F_FETCH = 3'd2,
      F_WAITD = 3'd3,
      F_REPLY = 3'd4
   } dir_fsm_e;

   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;

   localparam logic [1:0] MK_DATA      = 2'd0;
   localparam logic [1:0] MK_INV       = 2'd1;
   localparam logic [1:0] MK_FETCH     = 2'd2;
   localparam logic [1:0] MK_FETCH_INV = 2'd3;

endpackage

// File: rtl/dir_lowest_bit.sv
module dir_lowest_bit #(
   parameter int W  = 4,
   parameter int IW = 2
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [W-1:0]  first,
   output logic [IW-1:0] idx
);

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_bit
         if (g == 0) begin : g_low
            assign first[g] = vec[g];
         end else begin : g_high
            assign first[g] = vec[g] & ~(|vec[g-1:0]);
         end
      end
   endgenerate

   assign any = |vec;

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (first[i]) idx = idx | IW'(i);
      end
   end

endmodule

// File: rtl/dir_store.sv
module dir_store
   import dir_pkg::*;
#(
   parameter int N_NODES   = 4,
   parameter int N_BLOCKS  = 8,
   parameter int DATA_W    = 32,
   parameter int BLK_W     = 3,
   parameter bit CLEAR_MEM = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BLK_W-1:0]    rd_blk,
   output dir_state_e          rd_state,
   output logic [N_NODES-1:0]  rd_sh,
   output logic [DATA_W-1:0]   rd_mem,
   input  logic                dir_we,
   input  logic [BLK_W-1:0]    dir_blk,
   input  dir_state_e          dir_state_w,
   input  logic [N_NODES-1:0]  dir_sh_w,
   input  logic                mem_we,
   input  logic [BLK_W-1:0]    mem_blk,
   input  logic [DATA_W-1:0]   mem_wdata
);

   dir_state_e           st_q  [N_BLOCKS];
   logic [N_NODES-1:0]   sh_q  [N_BLOCKS];
   logic [DATA_W-1:0]    mem_q [N_BLOCKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < N_BLOCKS; b++) begin
            st_q[b] <= DS_UNC;
            sh_q[b] <= '0;
         end
      end else if (dir_we) begin
         st_q[dir_blk] <= dir_state_w;
         sh_q[dir_blk] <= dir_sh_w;
      end
   end

   generate
      if (CLEAR_MEM) begin : g_mem_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int b = 0; b < N_BLOCKS; b++) mem_q[b] <= '0;
            end else if (mem_we) begin
               mem_q[mem_blk] <= mem_wdata;
            end
         end
      end else begin : g_mem_raw
         always_ff @(posedge clk) begin
            if (mem_we) mem_q[mem_blk] <= mem_wdata;
         end
      end
   endgenerate

   assign rd_state = st_q[rd_blk];
   assign rd_sh    = sh_q[rd_blk];
   assign rd_mem   = mem_q[rd_blk];

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
   import dir_pkg::*;
#(
   parameter int N_NODES = 4,
   parameter int DATA_W  = 32,
   parameter int NID_W   = 2,
   parameter int BLK_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_kind,
   input  logic [NID_W-1:0]    req_node,
   input  logic [BLK_W-1:0]    req_blk,
   input  logic [DATA_W-1:0]   req_data,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [1:0]          msg_kind,
   output logic [NID_W-1:0]    msg_node,
   output logic [BLK_W-1:0]    msg_blk,
   output logic [DATA_W-1:0]   msg_data,
   input  logic                rsp_valid,
   output logic                rsp_ready,
   input  logic [DATA_W-1:0]   rsp_data,
   output logic [BLK_W-1:0]    rd_blk,
   input  dir_state_e          rd_state,
   input  logic [N_NODES-1:0]  rd_sh,
   input  logic [DATA_W-1:0]   rd_mem,
   output logic                dir_we,
   output logic [BLK_W-1:0]    dir_blk,
   output dir_state_e          dir_state_w,
   output logic [N_NODES-1:0]  dir_sh_w,
   output logic                mem_we,
   output logic [BLK_W-1:0]    mem_blk,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [N_NODES-1:0]  enc_vec,
   input  logic [N_NODES-1:0]  enc_first,
   input  logic [NID_W-1:0]    enc_idx
);

   dir_fsm_e             fsm_q, fsm_d;
   logic [NID_W-1:0]     node_q, node_d;
   logic [BLK_W-1:0]     blk_q, blk_d;
   logic [N_NODES-1:0]   inv_q, inv_d;
   logic [NID_W-1:0]     owner_q, owner_d;
   logic [DATA_W-1:0]    data_q, data_d;
   logic                 finv_q, finv_d;

   logic [N_NODES-1:0]   req_bit, node_bit, owner_bit, others;

   assign req_bit   = N_NODES'(1) << req_node;
   assign node_bit  = N_NODES'(1) << node_q;
   assign owner_bit = N_NODES'(1) << owner_q;
   assign others    = rd_sh & ~req_bit;

   always_comb begin
      fsm_d       = fsm_q;
      node_d      = node_q;
      blk_d       = blk_q;
      inv_d       = inv_q;
      owner_d     = owner_q;
      data_d      = data_q;
      finv_d      = finv_q;
      dir_we      = 1'b0;
      dir_blk     = blk_q;
      dir_state_w = DS_UNC;
      dir_sh_w    = '0;
      mem_we      = 1'b0;
      mem_blk     = blk_q;
      mem_wdata   = rsp_data;
      req_ready   = 1'b0;
      msg_valid   = 1'b0;
      msg_kind    = MK_DATA;
      msg_node    = node_q;
      msg_blk     = blk_q;
      msg_data    = '0;
      rsp_ready   = 1'b0;
      rd_blk      = (fsm_q == F_IDLE) ? req_blk : blk_q;
      enc_vec     = (fsm_q == F_IDLE) ? rd_sh : inv_q;

      unique case (fsm_q)
         F_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) begin
               node_d  = req_node;
               blk_d   = req_blk;
               dir_blk = req_blk;
               mem_blk = req_blk;
               data_d  = rd_mem;
               owner_d = enc_idx;
               case (req_kind)
                  RQ_READ: begin
                     if (rd_state == DS_EXC) begin
                        finv_d = 1'b0;
                        fsm_d  = F_FETCH;
                     end else begin
                        dir_we      = 1'b1;
                        dir_state_w = DS_SHR;
                        dir_sh_w    = (rd_state == DS_SHR) ? (rd_sh | req_bit) : req_bit;
                        fsm_d       = F_REPLY;
                     end
                  end
                  RQ_WRITE: begin
                     if (rd_state == DS_EXC) begin
                        finv_d = 1'b1;
                        fsm_d  = F_FETCH;
                     end else begin
                        dir_we      = 1'b1;
                        dir_state_w = DS_EXC;
                        dir_sh_w    = req_bit;
                        if (rd_state == DS_SHR && (|others)) begin
                           inv_d = others;
                           fsm_d = F_INV;
                        end else begin
                           fsm_d = F_REPLY;
                        end
                     end
                  end
                  RQ_WBACK: begin
                     if (rd_state == DS_EXC && (|(rd_sh & req_bit))) begin
                        dir_we      = 1'b1;
                        dir_state_w = DS_UNC;
                        dir_sh_w    = '0;
                        mem_we      = 1'b1;
                        mem_wdata   = req_data;
                     end
                  end
                  default: ;
               endcase
            end
         end
         F_INV: begin
            msg_valid = 1'b1;
            msg_kind  = MK_INV;
            msg_node  = enc_idx;
            if (msg_ready) begin
               inv_d = inv_q & ~enc_first;
               if ((inv_q & ~enc_first) == '0) fsm_d = F_REPLY;
            end
         end
         F_FETCH: begin
            msg_valid = 1'b1;
            msg_kind  = finv_q ? MK_FETCH_INV : MK_FETCH;
            msg_node  = owner_q;
            if (msg_ready) fsm_d = F_WAITD;
         end
         F_WAITD: begin
            rsp_ready = 1'b1;
            if (rsp_valid) begin
               mem_we      = 1'b1;
               data_d      = rsp_data;
               dir_we      = 1'b1;
               dir_state_w = finv_q ? DS_EXC : DS_SHR;
               dir_sh_w    = finv_q ? node_bit : (node_bit | owner_bit);
               fsm_d       = F_REPLY;
            end
         end
         F_REPLY: begin
            msg_valid = 1'b1;
            msg_kind  = MK_DATA;
            msg_data  = data_q;
            if (msg_ready) fsm_d = F_IDLE;
         end
         default: fsm_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q   <= F_IDLE;
         node_q  <= '0;
         blk_q   <= '0;
         inv_q   <= '0;
         owner_q <= '0;
         data_q  <= '0;
         finv_q  <= 1'b0;
      end else begin
         fsm_q   <= fsm_d;
         node_q  <= node_d;
         blk_q   <= blk_d;
         inv_q   <= inv_d;
         owner_q <= owner_d;
         data_q  <= data_d;
         finv_q  <= finv_d;
      end
   end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int N_NODES   = 4,
   parameter int N_BLOCKS  = 8,
   parameter int DATA_W    = 32,
   parameter bit CLEAR_MEM = 1'b1,
   parameter int NID_W     = $clog2(N_NODES),
   parameter int BLK_W     = $clog2(N_BLOCKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         req_kind,
   input  logic [NID_W-1:0]   req_node,
   input  logic [BLK_W-1:0]   req_blk,
   input  logic [DATA_W-1:0]  req_data,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [1:0]         msg_kind,
   output logic [NID_W-1:0]   msg_node,
   output logic [BLK_W-1:0]   msg_blk,
   output logic [DATA_W-1:0]  msg_data,
   input  logic               rsp_valid,
   output logic               rsp_ready,
   input  logic [DATA_W-1:0]  rsp_data
);

   generate
      if (N_NODES < 2 || N_NODES > 64) begin : g_bad_nodes
         $error("dir_home_ctrl: N_NODES must be in 2..64");
      end
      if (N_BLOCKS < 2 || N_BLOCKS > 1024) begin : g_bad_blocks
         $error("dir_home_ctrl: N_BLOCKS must be in 2..1024");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dir_home_ctrl: DATA_W must be positive");
      end
      if (NID_W != $clog2(N_NODES) || BLK_W != $clog2(N_BLOCKS)) begin : g_bad_derived
         $error("dir_home_ctrl: NID_W/BLK_W must not be overridden");
      end
   endgenerate

   logic [BLK_W-1:0]    rd_blk;
   dir_state_e          rd_state;
   logic [N_NODES-1:0]  rd_sh;
   logic [DATA_W-1:0]   rd_mem;
   logic                dir_we;
   logic [BLK_W-1:0]    dir_blk;
   dir_state_e          dir_state_w;
   logic [N_NODES-1:0]  dir_sh_w;
   logic                mem_we;
   logic [BLK_W-1:0]    mem_blk;
   logic [DATA_W-1:0]   mem_wdata;
   logic [N_NODES-1:0]  enc_vec, enc_first;
   logic                enc_any;
   logic [NID_W-1:0]    enc_idx;

   dir_store #(
      .N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W),
      .BLK_W(BLK_W), .CLEAR_MEM(CLEAR_MEM)
   ) i_store (
      .clk(clk), .rst_n(rst_n),
      .rd_blk(rd_blk), .rd_state(rd_state), .rd_sh(rd_sh), .rd_mem(rd_mem),
      .dir_we(dir_we), .dir_blk(dir_blk), .dir_state_w(dir_state_w), .dir_sh_w(dir_sh_w),
      .mem_we(mem_we), .mem_blk(mem_blk), .mem_wdata(mem_wdata)
   );

   dir_lowest_bit #(.W(N_NODES), .IW(NID_W)) i_enc (
      .vec(enc_vec), .any(enc_any), .first(enc_first), .idx(enc_idx)
   );

   dir_ctrl #(
      .N_NODES(N_NODES), .DATA_W(DATA_W), .NID_W(NID_W), .BLK_W(BLK_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .rd_blk(rd_blk), .rd_state(rd_state), .rd_sh(rd_sh), .rd_mem(rd_mem),
      .dir_we(dir_we), .dir_blk(dir_blk), .dir_state_w(dir_state_w), .dir_sh_w(dir_sh_w),
      .mem_we(mem_we), .mem_blk(mem_blk), .mem_wdata(mem_wdata),
      .enc_vec(enc_vec), .enc_first(enc_first), .enc_idx(enc_idx)
   );

   logic unused_any;
   assign unused_any = enc_any;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int DATA_W = 32,
   parameter int NID_W  = 2,
   parameter int BLK_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [1:0]         req_kind,
   input logic [NID_W-1:0]   req_node,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [1:0]         msg_kind,
   input logic [NID_W-1:0]   msg_node,
   input logic [BLK_W-1:0]   msg_blk,
   input logic [DATA_W-1:0]  msg_data,
   input logic               rsp_ready
);

   logic              req_hs, inv_hs;
   logic [NID_W-1:0]  cur_node;
   logic [NID_W-1:0]  inv_last;
   logic              inv_seen;

   assign req_hs = req_valid && req_ready;
   assign inv_hs = msg_valid && msg_ready && (msg_kind == 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_node <= '0;
         inv_last <= '0;
         inv_seen <= 1'b0;
      end else begin
         if (req_hs) begin
            cur_node <= req_node;
            inv_seen <= 1'b0;
         end else if (inv_hs) begin
            a_r5_inv_ascending: assert (!inv_seen || msg_node > inv_last)
               else $error("R5: invalidates out of ascending order");
            inv_last <= msg_node;
            inv_seen <= 1'b1;
         end
      end
   end

   a_r10_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hs && (req_kind == 2'd0 || req_kind == 2'd1)) |=> !req_ready);

   a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_node)
                                     && $stable(msg_blk) && $stable(msg_data)));

   a_r8_wback_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hs && req_kind == 2'd2) |=> (!msg_valid && req_ready));

   a_r9_unused_kind_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hs && req_kind == 2'd3) |=> (!msg_valid && req_ready));

   a_r5_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 2'd1) |-> (msg_node != cur_node));

   a_r6_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> (!msg_valid && !req_ready));

endmodule

bind dir_home_ctrl dir_home_chk #(
   .DATA_W(DATA_W), .NID_W(NID_W), .BLK_W(BLK_W)
) i_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_node(req_node),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
   .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data),
   .rsp_ready(rsp_ready)
);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NN = 4;
   localparam int NB = 8;
   localparam int DW = 32;
   localparam int NW = 2;
   localparam int BW = 3;

   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_XX = 2'd3;
   localparam logic [1:0] M_DATA = 2'd0, M_INV = 2'd1, M_FETCH = 2'd2, M_FINV = 2'd3;
   localparam int S_U = 0, S_S = 1, S_E = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [1:0] req_kind = '0;
   logic [NW-1:0] req_node = '0;
   logic [BW-1:0] req_blk = '0;
   logic [DW-1:0] req_data = '0;
   logic msg_valid, msg_ready = 1'b1;
   logic [1:0] msg_kind;
   logic [NW-1:0] msg_node;
   logic [BW-1:0] msg_blk;
   logic [DW-1:0] msg_data;
   logic rsp_valid = 1'b0, rsp_ready;
   logic [DW-1:0] rsp_data = '0;

   int checks = 0, failures = 0;
   bit stall_en = 1'b0;
   int cyc = 0;

   typedef struct packed {
      logic [1:0]    kind;
      logic [NW-1:0] node;
      logic [BW-1:0] blk;
      logic [DW-1:0] data;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   int            m_st  [NB];
   logic [NN-1:0] m_sh  [NB];
   logic [DW-1:0] m_mem [NB];

   dir_home_ctrl #(.N_NODES(NN), .N_BLOCKS(NB), .DATA_W(DW)) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] own_val(input logic [NW-1:0] n, input logic [BW-1:0] b);
      return 32'hC0DE_0000 | (32'(n) << 8) | 32'(b);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [NW-1:0] n, input logic [BW-1:0] b,
                       input logic [DW-1:0] d, input string tag);
      exp_t e;
      e.kind = k; e.node = n; e.blk = b; e.data = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // ready pattern for the message port
   initial forever begin
      @(posedge clk); #1;
      cyc++;
      msg_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
   end

   // owner node model: answer fetches with its own copy
   initial forever begin
      @(negedge clk);
      if (rst_n && msg_valid && msg_ready && (msg_kind == M_FETCH || msg_kind == M_FINV)) begin
         logic [DW-1:0] v;
         v = own_val(msg_node, msg_blk);
         @(posedge clk); #1;
         rsp_valid = 1'b1;
         rsp_data  = v;
         do @(negedge clk); while (!rsp_ready);
         @(posedge clk); #1;
         rsp_valid = 1'b0;
      end
   end

   // scoreboard monitor
   initial forever begin
      @(negedge clk);
      if (rst_n && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected message", {28'(msg_kind), 2'(0), msg_node}, '0);
         end else begin
            exp_t  e;
            string t;
            bit    ok;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ok = (msg_kind == e.kind) && (msg_node == e.node) && (msg_blk == e.blk);
            if (e.kind == M_DATA) ok = ok && (msg_data == e.data);
            check(ok, t, {msg_kind, 6'(msg_node), 8'(msg_blk), 16'(msg_data)},
                  {e.kind, 6'(e.node), 8'(e.blk), 16'(e.data)});
         end
      end
   end

   task automatic send(input logic [1:0] k, input logic [NW-1:0] n, input logic [BW-1:0] b,
                       input logic [DW-1:0] d);
      @(posedge clk); #1;
      req_valid = 1'b1; req_kind = k; req_node = n; req_blk = b; req_data = d;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      if (k == K_RD || k == K_WR)
         check(req_ready == 1'b0, "R10 busy after miss", 32'(req_ready), 32'd0);
      else
         check(req_ready == 1'b1 && msg_valid == 1'b0, "R8/R9 silent write-back",
               {30'd0, req_ready, msg_valid}, 32'd2);
   endtask

   // independent directory model driven by the requirements
   task automatic request(input logic [1:0] k, input logic [NW-1:0] n, input logic [BW-1:0] b,
                          input logic [DW-1:0] d, input string tag);
      logic [NN-1:0] nb;
      int owner;
      nb = NN'(1) << n;
      owner = 0;
      for (int i = 0; i < NN; i++) if (m_sh[b][i]) begin owner = i; break; end
      case (k)
         K_RD: begin
            if (m_st[b] == S_E) begin
               push(M_FETCH, NW'(owner), b, '0, {tag, " fetch"});
               m_mem[b] = own_val(NW'(owner), b);
               push(M_DATA, n, b, m_mem[b], {tag, " reply"});
               m_sh[b] = nb | (NN'(1) << owner);
            end else begin
               push(M_DATA, n, b, m_mem[b], {tag, " reply"});
               m_sh[b] = (m_st[b] == S_S) ? (m_sh[b] | nb) : nb;
            end
            m_st[b] = S_S;
         end
         K_WR: begin
            if (m_st[b] == S_E) begin
               push(M_FINV, NW'(owner), b, '0, {tag, " fetch-inv"});
               m_mem[b] = own_val(NW'(owner), b);
               push(M_DATA, n, b, m_mem[b], {tag, " reply"});
            end else begin
               if (m_st[b] == S_S)
                  for (int i = 0; i < NN; i++)
                     if (m_sh[b][i] && i != int'(n)) push(M_INV, NW'(i), b, '0, {tag, " inv"});
               push(M_DATA, n, b, m_mem[b], {tag, " reply"});
            end
            m_st[b] = S_E;
            m_sh[b] = nb;
         end
         K_WB: begin
            if (m_st[b] == S_E && m_sh[b][n]) begin
               m_mem[b] = d; m_st[b] = S_U; m_sh[b] = '0;
            end
         end
         default: ;
      endcase
      send(k, n, b, d);
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while ((exp_q.size() != 0 || !req_ready) && guard < 500) begin
         @(negedge clk);
         guard++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++) begin m_st[b] = S_U; m_sh[b] = '0; m_mem[b] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
      check(msg_valid == 1'b0, "R1 reset msg_valid", 32'(msg_valid), 32'd0);
      #1 rst_n = 1'b1;

      request(K_RD, 2'd1, 3'd0, '0, "R1 R2 read uncached zero");      drain();
      request(K_RD, 2'd3, 3'd0, '0, "R3 read shared");                drain();
      request(K_RD, 2'd0, 3'd0, '0, "R3 read shared again");          drain();
      stall_en = 1'b1;
      request(K_WR, 2'd3, 3'd0, '0, "R5 R11 write shared stalled");   drain();
      stall_en = 1'b0;
      request(K_RD, 2'd2, 3'd0, '0, "R6 read exclusive");             drain();
      stall_en = 1'b1;
      request(K_WR, 2'd1, 3'd0, '0, "R5 write shared two sharers");   drain();
      stall_en = 1'b0;
      request(K_WR, 2'd2, 3'd0, '0, "R7 write exclusive");            drain();
      request(K_WB, 2'd0, 3'd0, 32'hDEAD_BEEF, "R9 wb non-owner");    drain();
      request(K_WB, 2'd2, 3'd0, 32'h1234_5678, "R8 wb owner");        drain();
      request(K_RD, 2'd0, 3'd0, '0, "R8 read after wb");              drain();
      request(K_WB, 2'd0, 3'd0, 32'h0BAD_0BAD, "R9 wb to shared");    drain();
      request(K_XX, 2'd1, 3'd0, 32'h5555_AAAA, "R9 unused kind");     drain();
      request(K_RD, 2'd1, 3'd0, '0, "R9 read unchanged");             drain();
      request(K_WR, 2'd1, 3'd5, '0, "R4 write uncached");             drain();
      request(K_RD, 2'd2, 3'd5, '0, "R4 owner fetched");              drain();
      stall_en = 1'b1;
      request(K_WR, 2'd0, 3'd5, '0, "R5 R11 skip requester");         drain();
      stall_en = 1'b0;

      check(exp_q.size() == 0, "R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule